// File: doc/BRIEF.md
# Priority Interrupt Restart Opcode Generator

This block sits between eight peripheral request lines and a processor that has one interrupt input. When any request line is high, it raises a registered interrupt request toward the processor. When the processor answers with its active-low acknowledge, the block drives a one-byte restart opcode onto the shared 8-bit data bus. The opcode holds the number of the highest-numbered pending request, so the processor calls a fixed service address of eight times that number.

The bus is modelled as a data byte plus a separate output enable. The enable is high only while acknowledge is low. Outside acknowledge the data output reads zero. The winning request number is captured at the first clock edge that sees acknowledge low. From then on the byte stays fixed until acknowledge returns high, even if the request lines change. In the first cycle of the pulse, before that edge, the byte follows the live winner, so the opcode is on the bus from the moment acknowledge falls.

Top module: `irq_rst_vector`

## Requirements
- R1: When several request lines are high, the opcode encodes the highest-numbered one (bit n of `req_i` is request n).
- R2: The opcode has bits 7, 6, 2, 1 and 0 set, and bits 5..3 hold the 3-bit winning number. Requests 0 to 7 give C7h, CFh, D7h, DFh, E7h, EFh, F7h and FFh, so request 2 alone gives D7h.
- R3: Bits 5..3 of the opcode, read in place as a byte, equal the call target n×8 (0000h to 0038h) of the winning request n.
- R4: `bus_oe_o` is high exactly while `ack_n_i` is low. While it is low, `bus_data_o` is 00h.
- R5: `irq_o` is the OR of all eight request lines, registered once. A change on the request lines reaches `irq_o` at the next rising clock edge and not earlier.
- R6: The winning number is captured at the first rising edge that samples `ack_n_i` low. For the rest of that acknowledge pulse the byte does not change, whatever the request lines do.
- R7: In the cycle in which `ack_n_i` has fallen but no edge has yet sampled it low, the byte reflects the current winner of the request lines.
- R8: While `rst_n` is low, `irq_o`, `bus_oe_o` and `bus_data_o` are all zero when `ack_n_i` is high.
- R9: An acknowledge with no request line high yields the opcode for request 0, C7h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Peripheral request lines, active high, bit n is request n |
| ack_n_i | input | 1 | Interrupt acknowledge from the processor, active low |
| irq_o | output | 1 | Registered interrupt request to the processor |
| bus_oe_o | output | 1 | Data bus drive enable, high while acknowledge is low |
| bus_data_o | output | 8 | Restart opcode byte, zero while the bus is released |

## Verification
The assertions assume that `ack_n_i` and `req_i` are synchronous to `clk` and change only between rising edges. They do not assume that requests hold still during acknowledge. The bench drives every input on the falling edge, so each value is settled well before the next rising edge. It changes the request lines in the middle of acknowledge pulses on purpose, and it also holds some pulses for several cycles, so the capture path and the first-cycle bypass are both exercised within these assumptions.

// File: rtl/prio_rst_pkg.sv
package prio_rst_pkg;

   // phase of the acknowledge pulse as seen by the capture logic
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,
      ACK_FIRST = 2'd1,
      ACK_HELD  = 2'd2
   } ack_phase_e;

   localparam int unsigned DEF_N_REQ     = 8;
   localparam int unsigned DEF_DATA_W    = 8;
   localparam int unsigned DEF_FIELD_LSB = 3;
   localparam logic [7:0]  DEF_BASE_OP   = 8'hC7;

endpackage

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
   parameter int unsigned N_REQ     = 8,
   parameter bit          HIGH_WINS = 1'b1,
   localparam int unsigned IDX_W    = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   generate
      if (HIGH_WINS) begin : g_high
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < N_REQ; i++) begin
               if (req_i[i]) idx_o = IDX_W'(i);
            end
         end
      end else begin : g_low
         always_comb begin
            idx_o = '0;
            for (int i = N_REQ - 1; i >= 0; i--) begin
               if (req_i[i]) idx_o = IDX_W'(i);
            end
         end
      end
   endgenerate

   assign any_o = |req_i;

   // the chosen line must actually be requesting
   always_comb begin
      if (any_o) begin
         AST_WINNER_ACTIVE: assert (req_i[idx_o]); // R1
      end
   end

   generate
      if (HIGH_WINS) begin : g_chk_high
         always_comb begin
            if (any_o) begin
               AST_NONE_ABOVE: assert ((req_i >> idx_o) == N_REQ'(1)); // R1
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_opcode_build.sv
module irq_opcode_build #(
   parameter int unsigned  DATA_W    = 8,
   parameter int unsigned  IDX_W     = 3,
   parameter int unsigned  FIELD_LSB = 3,
   parameter logic [DATA_W-1:0] BASE_OP = 8'hC7
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [DATA_W-1:0] op_o
);

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b >= FIELD_LSB && b < FIELD_LSB + IDX_W) begin : g_field
            assign op_o[b] = idx_i[b - FIELD_LSB];
         end else begin : g_fixed
            assign op_o[b] = BASE_OP[b];
         end
      end
   endgenerate

endmodule

// File: rtl/irq_ack_capture.sv
module irq_ack_capture
   import prio_rst_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_n_i,
   input  logic [IDX_W-1:0] live_idx_i,
   output logic             oe_o,
   output logic [IDX_W-1:0] sel_idx_o
);

   logic             ack_q;
   logic [IDX_W-1:0] held_idx;
   ack_phase_e       phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b1;
      else        ack_q <= ack_n_i;
   end

   always_comb begin
      if (ack_n_i)    phase = ACK_IDLE;
      else if (ack_q) phase = ACK_FIRST;
      else            phase = ACK_HELD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  held_idx <= '0;
      else if (phase == ACK_FIRST) held_idx <= live_idx_i;
   end

   assign oe_o      = (phase != ACK_IDLE);
   assign sel_idx_o = (phase == ACK_FIRST) ? live_idx_i : held_idx;

   // once held, the captured number may not move within the pulse
   AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ACK_HELD) |=> (ack_n_i || $stable(held_idx))); // R6

   // the first-cycle phase lasts exactly one cycle per pulse
   AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ACK_FIRST) |=> (phase != ACK_FIRST)); // R6

endmodule

// File: rtl/irq_rst_vector.sv
module irq_rst_vector
   import prio_rst_pkg::*;
#(
   parameter int unsigned N_REQ     = DEF_N_REQ,
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned FIELD_LSB = DEF_FIELD_LSB,
   parameter logic [DATA_W-1:0] BASE_OP = DEF_BASE_OP,
   parameter bit          HIGH_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REQ-1:0]  req_i,
   input  logic              ack_n_i,
   output logic              irq_o,
   output logic              bus_oe_o,
   output logic [DATA_W-1:0] bus_data_o
);

   localparam int unsigned IDX_W = $clog2(N_REQ);
   localparam logic [DATA_W-1:0] FIELD_MASK =
      DATA_W'(((1 << IDX_W) - 1) << FIELD_LSB);

   generate
      if (N_REQ < 2 || (1 << IDX_W) != N_REQ) begin : g_bad_nreq
         $error("N_REQ must be a power of two of at least 2");
      end
      if (FIELD_LSB + IDX_W > DATA_W) begin : g_bad_field
         $error("number field does not fit inside the opcode");
      end
   endgenerate

   logic             any_req;
   logic [IDX_W-1:0] live_idx;
   logic [IDX_W-1:0] sel_idx;
   logic [DATA_W-1:0] opcode;
   logic             drive;
   logic             irq_q;
   logic             chk_arm;

   irq_prio_resolve #(
      .N_REQ     (N_REQ),
      .HIGH_WINS (HIGH_WINS)
   ) i_resolve (
      .req_i (req_i),
      .any_o (any_req),
      .idx_o (live_idx)
   );

   irq_ack_capture #(
      .IDX_W (IDX_W)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_n_i    (ack_n_i),
      .live_idx_i (live_idx),
      .oe_o       (drive),
      .sel_idx_o  (sel_idx)
   );

   irq_opcode_build #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .FIELD_LSB (FIELD_LSB),
      .BASE_OP   (BASE_OP)
   ) i_build (
      .idx_i (sel_idx),
      .op_o  (opcode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= any_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_arm <= 1'b0;
      else        chk_arm <= 1'b1;
   end

   assign irq_o      = irq_q;
   assign bus_oe_o   = drive;
   assign bus_data_o = drive ? opcode : '0;

   AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !chk_arm)
      irq_o == $past(|req_i)); // R5

   AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (((bus_data_o ^ BASE_OP) & ~FIELD_MASK) == '0)); // R2

   AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_o |-> (bus_data_o == '0)); // R4

   AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !chk_arm)
      (!ack_n_i && $past(!ack_n_i)) |-> $stable(bus_data_o)); // R6

endmodule

// File: tb/test_irq_rst_vector.sv
module test_irq_rst_vector;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] req_i;
   logic       ack_n_i;
   logic       irq_o;
   logic       bus_oe_o;
   logic [7:0] bus_data_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_rst_vector i_irq_rst_vector (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .ack_n_i    (ack_n_i),
      .irq_o      (irq_o),
      .bus_oe_o   (bus_oe_o),
      .bus_data_o (bus_data_o)
   );

   function automatic int winner(input logic [7:0] r);
      winner = 0;
      for (int i = 7; i >= 0; i--) begin
         if (r[i]) return i;
      end
   endfunction

   function automatic logic [7:0] exp_op(input int n);
      logic [2:0] f;
      f = 3'(n);
      exp_op = {2'b11, f, 3'b111};
   endfunction

   function automatic logic [15:0] call_target(input int n);
      call_target = 16'(n * 8);
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive on the falling edge, sample shortly before the rising edge
   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic probe();
      #5;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, r2, prev, held;
      int n;
      void'($urandom(32'd1234));
      rst_n = 1'b0; req_i = 8'h00; ack_n_i = 1'b1;
      cyc(); req_i = 8'hFF; probe();
      chk("R8 irq in reset", 16'(irq_o), 16'h0);
      chk("R8 oe in reset", 16'(bus_oe_o), 16'h0);
      chk("R8 data in reset", 16'(bus_data_o), 16'h0);
      cyc(); rst_n = 1'b1; req_i = 8'h00;
      cyc(); cyc();

      // R5 one-edge latency
      cyc(); req_i = 8'h10; probe();
      chk("R5 irq before edge", 16'(irq_o), 16'h0);
      cyc(); probe();
      chk("R5 irq after edge", 16'(irq_o), 16'h1);

      // R2 directed example: request 2 alone
      cyc(); req_i = 8'h04;
      cyc(); ack_n_i = 1'b0; probe();
      chk("R7 R2 byte for request 2", 16'(bus_data_o), 16'h00D7);
      chk("R4 oe during ack", 16'(bus_oe_o), 16'h1);
      cyc(); ack_n_i = 1'b1; probe();
      chk("R4 oe after ack", 16'(bus_oe_o), 16'h0);
      chk("R4 data released", 16'(bus_data_o), 16'h0);

      // R2 R3 every single request
      for (int k = 0; k < 8; k++) begin
         cyc(); req_i = 8'(1 << k); ack_n_i = 1'b0; probe();
         chk($sformatf("R2 opcode req%0d", k), 16'(bus_data_o), 16'(exp_op(k)));
         chk($sformatf("R3 target req%0d", k), {8'h00, bus_data_o & 8'h38}, call_target(k));
         cyc(); ack_n_i = 1'b1;
      end

      // R1 all lines high and a low pair
      cyc(); req_i = 8'hFF; ack_n_i = 1'b0; probe();
      chk("R1 all high", 16'(bus_data_o), 16'h00FF);
      cyc(); ack_n_i = 1'b1;
      cyc(); req_i = 8'h03; ack_n_i = 1'b0; probe();
      chk("R1 lines 0 and 1", 16'(bus_data_o), 16'h00CF);
      cyc(); ack_n_i = 1'b1;

      // R9 acknowledge with nothing pending
      cyc(); req_i = 8'h00;
      cyc(); ack_n_i = 1'b0; probe();
      chk("R9 no request", 16'(bus_data_o), 16'h00C7);
      cyc(); ack_n_i = 1'b1;

      // R6 long pulse with requests changing every cycle
      cyc(); req_i = 8'h21; ack_n_i = 1'b0; probe();
      chk("R6 long pulse start", 16'(bus_data_o), 16'h00EF);
      for (int k = 0; k < 4; k++) begin
         cyc(); req_i = 8'($urandom); probe();
         chk("R6 long pulse hold", 16'(bus_data_o), 16'h00EF);
      end
      cyc(); ack_n_i = 1'b1; req_i = 8'h00;
      cyc();

      // random mix
      prev = 8'h00;
      for (int it = 0; it < 300; it++) begin
         r = 8'($urandom);
         if ((it % 7) == 0) r = 8'h00;
         cyc(); req_i = r; ack_n_i = 1'b1; probe();
         chk("R5 irq random", 16'(irq_o), 16'(|prev));
         chk("R4 released random", 16'({bus_oe_o, bus_data_o}), 16'h0);
         cyc(); ack_n_i = 1'b0; probe();
         n = winner(r);
         chk("R1 R7 byte random", 16'(bus_data_o), 16'(exp_op(n)));
         chk("R3 target random", {8'h00, bus_data_o & 8'h38}, call_target(n));
         held = bus_data_o;
         r2 = 8'($urandom);
         cyc(); req_i = r2; probe();
         chk("R6 held random", 16'(bus_data_o), 16'(held));
         chk("R5 irq during ack", 16'(irq_o), 16'(|r));
         cyc(); ack_n_i = 1'b1; probe();
         chk("R4 oe drops random", 16'(bus_oe_o), 16'h0);
         prev = r2;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule